// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-facing side of a synchronous serial port. A processor reaches it through a small register bus with a byte address, separate read and write strobes and 16-bit data. It holds two control words, a clock prescale value, a data port, a status word and an interrupt status word that also acts as a clear port. Behind the data port sit a transmit queue and a receive queue, each eight words deep by default.

The shift engine that drives the serial wires sits on the other side. It is offered the oldest transmit word with a valid flag and takes it with a one-cycle strobe. It hands back each completed frame with a one-cycle valid strobe. The block forwards the control fields the engine needs (first control word, prescale, loopback, slave select, output disable). It raises a single interrupt line from three request sources: receive queue at least half full, transmit queue at most half full, and a sticky receive overrun. No frame moves in either direction while the port-enable bit is clear.

Top module: `serport_regs`

## Requirements
- R1: After synchronous reset all control words and the prescale read as zero, the status word reads 0x03, the interrupt status reads 0x02 and `irq` is low.
- R2: The first control word (offset 0x00, 16 bits), the second control word (offset 0x04, low 7 bits) and the prescale (offset 0x10, low 8 bits) read back what was written. Unmapped offsets read zero.
- R3: A write to offset 0x08 appends the word to the transmit queue. When the queue already holds 8 words the write is dropped. The engine receives the words oldest first.
- R4: A read of offset 0x08 returns the oldest received word and removes it. On an empty receive queue the read returns zero and changes nothing.
- R5: The status word at offset 0x0C has transmit empty at bit 0, transmit not full at bit 1, receive not empty at bit 2, receive full at bit 3 and busy at bit 4.
- R6: While port enable (second control word bit 4) is clear, `eng_tx_valid` stays low, `eng_tx_take` removes nothing and incoming frames are neither stored nor counted as overrun.
- R7: Interrupt status bit 0 (receive request) is set while the receive queue holds 4 or more words. Bit 1 (transmit request) is set while the transmit queue holds 4 or fewer words.
- R8: A frame that arrives while the port is enabled and the receive queue is full is discarded. It sets interrupt status bit 2 (overrun), which stays set until cleared.
- R9: Any write to offset 0x14 clears the overrun flag. If a new overrun happens in the same cycle, the flag stays set.
- R10: `irq` is high exactly when some interrupt status bit is set and its enable in the second control word is set: bit 0 enables receive request, bit 1 transmit request, bit 2 overrun.
- R11: `cfg_ctrl0` and `cfg_prescale` carry the stored control word and prescale. `cfg_loopback`, `cfg_slave` and `cfg_out_dis` carry second control word bits 3, 5 and 6.
- R12: Busy reads high when the port is enabled and either the engine reports busy or the transmit queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the receive queue at the data offset) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Combined interrupt request |
| eng_tx_valid | output | 1 | A transmit word is available to the engine |
| eng_tx_data | output | 16 | Oldest transmit word |
| eng_tx_take | input | 1 | Engine consumes the offered word |
| eng_rx_valid | input | 1 | Engine delivers a completed frame |
| eng_rx_data | input | 16 | Received frame word |
| eng_busy | input | 1 | Engine is shifting a frame |
| cfg_ctrl0 | output | 16 | First control word to the engine |
| cfg_prescale | output | 8 | Prescale value to the engine |
| cfg_loopback | output | 1 | Loopback select |
| cfg_slave | output | 1 | Slave mode select |
| cfg_out_dis | output | 1 | Slave output disable |

## Verification
The embedded properties check on every cycle that the queue occupancy never exceeds its depth and a push into a full queue leaves it unchanged. They also check that a disabled port neither offers transmit words nor stores frames, that the overrun flag holds until a clear, and that a clear without a new overrun removes it. Word ordering through both queues, the half-full request thresholds, the exact status and interrupt encodings, the clear-versus-set collision and the zero returned by an empty read can only be shown by the bench's scenarios. There a behavioural queue model predicts every output on every cycle.

// File: rtl/serport_pkg.sv
package serport_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL0 = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL1 = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_PSC   = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_INT   = 5'h14;

    // second control word, bit 6 down to bit 0
    typedef struct packed {
        logic out_dis;
        logic slave_sel;
        logic port_en;
        logic loopback;
        logic ovr_ie;
        logic tx_ie;
        logic rx_ie;
    } ctrl1_t;

    // status word, bit 4 down to bit 0
    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_nempty;
        logic tx_nfull;
        logic tx_empty;
    } stat_t;

    // interrupt status, bit 2 down to bit 0
    typedef struct packed {
        logic ovr;
        logic tx_req;
        logic rx_req;
    } intr_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL0,
        SEL_CTRL1,
        SEL_DATA,
        SEL_STAT,
        SEL_PSC,
        SEL_INT
    } regsel_e;

    function automatic regsel_e decode_addr(input logic [ADDR_W-1:0] a);
        regsel_e s;
        case (a)
            OFS_CTRL0: s = SEL_CTRL0;
            OFS_CTRL1: s = SEL_CTRL1;
            OFS_DATA:  s = SEL_DATA;
            OFS_STAT:  s = SEL_STAT;
            OFS_PSC:   s = SEL_PSC;
            OFS_INT:   s = SEL_INT;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/serport_fifo.sv
module serport_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    input  logic                         pop,
    output logic [WIDTH-1:0]             head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R3
    full_push_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == FULL_CNT));

endmodule

// File: rtl/serport_intr.sv
module serport_intr
    import serport_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(DEPTH+1)-1:0]   rx_count,
    input  logic [$clog2(DEPTH+1)-1:0]   tx_count,
    input  logic                         ovr_set,
    input  logic                         ovr_clr,
    input  ctrl1_t                       ctrl,
    output intr_t                        raw,
    output logic                         irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

    logic ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= 1'b0;
        end else if (ovr_set) begin
            ovr_q <= 1'b1;
        end else if (ovr_clr) begin
            ovr_q <= 1'b0;
        end
    end

    always_comb begin
        raw.rx_req = (rx_count >= HALF);
        raw.tx_req = (tx_count <= HALF);
        raw.ovr    = ovr_q;
        irq = (raw.rx_req && ctrl.rx_ie) ||
              (raw.tx_req && ctrl.tx_ie) ||
              (raw.ovr    && ctrl.ovr_ie);
    end

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (raw.ovr && !ovr_clr) |=> raw.ovr);

    // R9
    ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_clr && !ovr_set) |=> !raw.ovr);

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl.rx_ie || ctrl.tx_ie || ctrl.ovr_ie));

endmodule

// File: rtl/serport_regs.sv
module serport_regs
    import serport_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int PSC_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              eng_tx_valid,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_tx_take,
    input  logic              eng_rx_valid,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_busy,
    output logic [DATA_W-1:0] cfg_ctrl0,
    output logic [PSC_W-1:0]  cfg_prescale,
    output logic              cfg_loopback,
    output logic              cfg_slave,
    output logic              cfg_out_dis
);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int CTRL1_W = $bits(ctrl1_t);

    regsel_e             sel;
    logic [DATA_W-1:0]   ctrl0_q;
    ctrl1_t              ctrl1_q;
    logic [PSC_W-1:0]    psc_q;

    logic                tx_push, tx_pop, tx_full, tx_empty;
    logic [CNT_W-1:0]    tx_count;
    logic [DATA_W-1:0]   tx_head;

    logic                rx_push, rx_pop, rx_full, rx_empty;
    logic [CNT_W-1:0]    rx_count;
    logic [DATA_W-1:0]   rx_head;

    logic                frame_in, ovr_set, ovr_clr;
    stat_t               stat;
    intr_t               raw;

    assign sel = decode_addr(bus_addr);

    // control register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl0_q <= '0;
            ctrl1_q <= '0;
            psc_q   <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_CTRL0: ctrl0_q <= bus_wdata;
                SEL_CTRL1: ctrl1_q <= ctrl1_t'(bus_wdata[CTRL1_W-1:0]);
                SEL_PSC:   psc_q   <= bus_wdata[PSC_W-1:0];
                default: ;
            endcase
        end
    end

    // queue control
    assign tx_push  = bus_wr && (sel == SEL_DATA);
    assign tx_pop   = eng_tx_take && eng_tx_valid;
    assign frame_in = eng_rx_valid && ctrl1_q.port_en;
    assign rx_push  = frame_in && !rx_full;
    assign ovr_set  = frame_in && rx_full;
    assign rx_pop   = bus_rd && (sel == SEL_DATA);
    assign ovr_clr  = bus_wr && (sel == SEL_INT);

    serport_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .din   (bus_wdata),
        .pop   (tx_pop),
        .head  (tx_head),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    serport_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .din   (eng_rx_data),
        .pop   (rx_pop),
        .head  (rx_head),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    serport_intr #(.DEPTH(FIFO_DEPTH)) intr_i (
        .clk      (clk),
        .rst      (rst),
        .rx_count (rx_count),
        .tx_count (tx_count),
        .ovr_set  (ovr_set),
        .ovr_clr  (ovr_clr),
        .ctrl     (ctrl1_q),
        .raw      (raw),
        .irq      (irq)
    );

    // status and engine side
    always_comb begin
        stat.tx_empty  = tx_empty;
        stat.tx_nfull  = !tx_full;
        stat.rx_nempty = !rx_empty;
        stat.rx_full   = rx_full;
        stat.busy      = ctrl1_q.port_en && (eng_busy || !tx_empty);
    end

    assign eng_tx_valid = ctrl1_q.port_en && !tx_empty;
    assign eng_tx_data  = tx_head;
    assign cfg_ctrl0    = ctrl0_q;
    assign cfg_prescale = psc_q;
    assign cfg_loopback = ctrl1_q.loopback;
    assign cfg_slave    = ctrl1_q.slave_sel;
    assign cfg_out_dis  = ctrl1_q.out_dis;

    // read mux
    always_comb begin
        case (sel)
            SEL_CTRL0: bus_rdata = ctrl0_q;
            SEL_CTRL1: bus_rdata = DATA_W'(ctrl1_q);
            SEL_DATA:  bus_rdata = rx_head;
            SEL_STAT:  bus_rdata = DATA_W'(stat);
            SEL_PSC:   bus_rdata = DATA_W'(psc_q);
            SEL_INT:   bus_rdata = DATA_W'(raw);
            default:   bus_rdata = '0;
        endcase
    end

    // R6
    tx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl1_q.port_en |-> !eng_tx_valid);

    // R6
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl1_q.port_en && !rx_pop) |=> $stable(rx_count));

endmodule

// File: tb/serport_regs_tb_top.sv
module serport_regs_tb_top;
    import serport_pkg::*;

    localparam int DW    = 16;
    localparam int DEPTH = 8;
    localparam int PW    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [ADDR_W-1:0] addr = '0;
    logic              wr = 1'b0, rd = 1'b0;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata;
    logic              irq;
    logic              eng_tx_valid;
    logic [DW-1:0]     eng_tx_data;
    logic              eng_tx_take = 1'b0;
    logic              eng_rx_valid = 1'b0;
    logic [DW-1:0]     eng_rx_data = '0;
    logic              eng_busy = 1'b0;
    logic [DW-1:0]     cfg_ctrl0;
    logic [PW-1:0]     cfg_prescale;
    logic              cfg_loopback, cfg_slave, cfg_out_dis;

    serport_regs #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .PSC_W(PW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (addr),
        .bus_wr       (wr),
        .bus_rd       (rd),
        .bus_wdata    (wdata),
        .bus_rdata    (rdata),
        .irq          (irq),
        .eng_tx_valid (eng_tx_valid),
        .eng_tx_data  (eng_tx_data),
        .eng_tx_take  (eng_tx_take),
        .eng_rx_valid (eng_rx_valid),
        .eng_rx_data  (eng_rx_data),
        .eng_busy     (eng_busy),
        .cfg_ctrl0    (cfg_ctrl0),
        .cfg_prescale (cfg_prescale),
        .cfg_loopback (cfg_loopback),
        .cfg_slave    (cfg_slave),
        .cfg_out_dis  (cfg_out_dis)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [DW-1:0] txq[$];
    logic [DW-1:0] rxq[$];
    logic [DW-1:0] m_c0;
    logic [6:0]    m_c1;
    logic [PW-1:0] m_psc;
    logic          m_ovr;
    bit m_en, m_txpop, m_txpush, m_frame, m_rxpop, m_rxfull;

    always @(posedge clk) begin
        if (rst) begin
            txq.delete();
            rxq.delete();
            m_c0 = '0; m_c1 = '0; m_psc = '0; m_ovr = 1'b0;
        end else begin
            m_en     = m_c1[4];
            m_txpop  = eng_tx_take && m_en && (txq.size() > 0);
            m_txpush = wr && (addr == 5'h08) && (txq.size() < DEPTH);
            m_frame  = eng_rx_valid && m_en;
            m_rxpop  = rd && (addr == 5'h08) && (rxq.size() > 0);
            m_rxfull = (rxq.size() == DEPTH);
            if (m_txpop)  void'(txq.pop_front());
            if (m_txpush) txq.push_back(wdata);
            if (m_rxpop)  void'(rxq.pop_front());
            if (m_frame && !m_rxfull) rxq.push_back(eng_rx_data);
            if (m_frame && m_rxfull) m_ovr = 1'b1;
            else if (wr && addr == 5'h14) m_ovr = 1'b0;
            if (wr && addr == 5'h00) m_c0  = wdata;
            if (wr && addr == 5'h04) m_c1  = wdata[6:0];
            if (wr && addr == 5'h10) m_psc = wdata[PW-1:0];
        end
    end

    function automatic string tag_of(input logic [ADDR_W-1:0] a);
        case (a)
            5'h08:   return "R4";
            5'h0C:   return "R5";
            5'h14:   return "R7";
            default: return "R2";
        endcase
    endfunction

    logic [4:0]    e_stat;
    logic [2:0]    e_int;
    logic [DW-1:0] e_rd;
    logic          e_txv;

    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            e_stat = {m_c1[4] && (eng_busy || txq.size() > 0),
                      rxq.size() == DEPTH, rxq.size() > 0,
                      txq.size() < DEPTH, txq.size() == 0};
            e_int  = {m_ovr, txq.size() <= DEPTH/2, rxq.size() >= DEPTH/2};
            case (addr)
                5'h00:   e_rd = m_c0;
                5'h04:   e_rd = DW'(m_c1);
                5'h08:   e_rd = (rxq.size() > 0) ? rxq[0] : '0;
                5'h0C:   e_rd = DW'(e_stat);
                5'h10:   e_rd = DW'(m_psc);
                5'h14:   e_rd = DW'(e_int);
                default: e_rd = '0;
            endcase
            e_txv = m_c1[4] && (txq.size() > 0);
            chk(tag_of(addr), "bus_rdata", int'(rdata), int'(e_rd));
            chk("R10", "irq", int'(irq), int'(|(e_int & m_c1[2:0])));
            chk("R6", "eng_tx_valid", int'(eng_tx_valid), int'(e_txv));
            if (e_txv) chk("R3", "eng_tx_data", int'(eng_tx_data), int'(txq[0]));
            chk("R11", "cfg outputs",
                int'({cfg_out_dis, cfg_slave, cfg_loopback, cfg_prescale, cfg_ctrl0}),
                int'({m_c1[6], m_c1[5], m_c1[3], m_psc, m_c0}));
        end
    end

    // ---------------- stimulus tasks (entered at a falling edge) ----------------
    task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [ADDR_W-1:0] a, input int exp, input string tag);
        addr = a; rd = 1'b1;
        #2;
        chk(tag, "read", int'(rdata), exp);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic peek(input logic [ADDR_W-1:0] a, input int exp, input string tag);
        addr = a;
        #2;
        chk(tag, "peek", int'(rdata), exp);
        @(negedge clk);
    endtask

    task automatic frame(input logic [DW-1:0] d);
        eng_rx_valid = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_valid = 1'b0;
    endtask

    task automatic take_word(input int exp, input string tag);
        #2;
        chk(tag, "offered word", int'(eng_tx_data), exp);
        eng_tx_take = 1'b1;
        @(negedge clk);
        eng_tx_take = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        peek(5'h0C, 32'h03, "R1");
        peek(5'h14, 32'h02, "R1");
        peek(5'h04, 32'h00, "R1");
        peek(5'h00, 32'h00, "R1");
        chk("R1", "irq after reset", int'(irq), 0);

        // R2 / R11 control readback and forwarding
        wr_reg(5'h00, 16'hA5C3);
        wr_reg(5'h10, 16'hFF0E);
        wr_reg(5'h04, 16'hFF68);
        peek(5'h00, 32'hA5C3, "R2");
        peek(5'h10, 32'h0E, "R2");
        peek(5'h04, 32'h68, "R2");
        peek(5'h18, 32'h00, "R2");
        chk("R11", "loopback", int'(cfg_loopback), 1);
        chk("R11", "slave", int'(cfg_slave), 1);
        chk("R11", "out_dis", int'(cfg_out_dis), 1);
        chk("R11", "prescale", int'(cfg_prescale), 32'h0E);

        // R6 disabled port: no transfers either way
        for (int i = 0; i < 3; i++) wr_reg(5'h08, 16'(16'h0100 + i));
        chk("R6", "tx valid while disabled", int'(eng_tx_valid), 0);
        eng_tx_take = 1'b1;
        @(negedge clk);
        eng_tx_take = 1'b0;
        frame(16'hDEAD);
        peek(5'h0C, 32'h02, "R6");

        // R3 fill transmit queue past its depth
        for (int i = 3; i < 9; i++) wr_reg(5'h08, 16'(16'h0100 + i));
        peek(5'h0C, 32'h00, "R3");
        peek(5'h14, 32'h00, "R7");

        // enable and drain in order
        wr_reg(5'h04, 16'h0010);
        peek(5'h0C, 32'h10, "R12");
        for (int i = 0; i < 8; i++) take_word(16'h0100 + i, "R3");
        chk("R3", "ninth word dropped", int'(eng_tx_valid), 0);
        peek(5'h0C, 32'h03, "R5");

        // R7 receive request threshold
        for (int i = 0; i < 3; i++) frame(16'(16'h2000 + i));
        peek(5'h14, 32'h02, "R7");
        frame(16'h2003);
        peek(5'h14, 32'h03, "R7");
        for (int i = 4; i < 8; i++) frame(16'(16'h2000 + i));
        peek(5'h0C, 32'h0F, "R5");

        // R8 overrun, sticky
        frame(16'h2008);
        peek(5'h14, 32'h07, "R8");
        repeat (3) @(negedge clk);
        peek(5'h14, 32'h07, "R8");

        // R10 interrupt masking
        wr_reg(5'h04, 16'h0014);
        chk("R10", "irq overrun enabled", int'(irq), 1);

        // R9 clear colliding with a new overrun
        addr = 5'h14; wdata = 16'h0000; wr = 1'b1;
        eng_rx_valid = 1'b1; eng_rx_data = 16'hBEEF;
        @(negedge clk);
        wr = 1'b0; eng_rx_valid = 1'b0;
        peek(5'h14, 32'h07, "R9");
        wr_reg(5'h14, 16'h1234);
        peek(5'h14, 32'h03, "R9");
        chk("R10", "irq after clear", int'(irq), 0);
        wr_reg(5'h04, 16'h0011);
        chk("R10", "irq rx request", int'(irq), 1);

        // R4 draining receive queue, empty read
        for (int i = 0; i < 8; i++) rd_reg(5'h08, 16'h2000 + i, "R4");
        rd_reg(5'h08, 32'h0000, "R4");
        peek(5'h0C, 32'h03, "R4");

        // R12 busy
        eng_busy = 1'b1;
        peek(5'h0C, 32'h13, "R12");
        wr_reg(5'h04, 16'h0000);
        peek(5'h0C, 32'h03, "R12");
        eng_busy = 1'b0;
        repeat (2) @(negedge clk);

        finish_run();
    end

endmodule